// File: doc/BRIEF.md
# Selectable-Source Time Base Counter

A wide free-running counter for the main system clock domain that serves as a chip time base. Each count step comes from one of two tick sources. One is an internal prescaler that produces a tick every eighth system clock. The other is a slow real-time clock pin that is asynchronous to the system clock. That pin is brought into the system domain through a two-stage synchronizer, and a rising edge on it is then detected by one more register.

Software-facing logic elsewhere drives three controls. An enable bit gates all counting. A select bit picks the tick source. A synchronous load port overwrites the count. The block reports the current count. It also drives a strobe that is high in exactly those cycles where the count steps at the next clock edge.

The real-time clock input is assumed to run at no more than a quarter of the system clock rate. At that rate every one of its edges survives synchronization.

Top module: `timebase_counter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `count_o` is 0 and `tick_o` is 0. The prescaler starts with a zero phase, and the tick source is the prescaler (`src_sel_i` = 0).
- R2: With `en_i` low, `count_o` holds its value, `tick_o` stays low, and edges on `rtc_async_i` have no effect.
- R3: With `en_i` high and `src_sel_i` = 0, `count_o` steps by one on every eighth rising edge of `clk`. Edges on `rtc_async_i` do not step it.
- R4: With `en_i` high and `src_sel_i` = 1, `count_o` steps by one for each rising edge of `rtc_async_i`. The step occurs on the third `clk` edge after the pin rises: two synchronizer stages, then the edge register.
- R5: The prescaler phase returns to zero in every cycle where `en_i` is low. After `en_i` rises, the first step therefore lands on the eighth `clk` edge with `en_i` high.
- R6: `load_i` high at a clock edge writes `load_val_i` into `count_o`, even if a tick is due in the same cycle. `tick_o` is low in any cycle where `load_i` is high.
- R7: A step from the all-ones count gives zero.
- R8: `tick_o` is high in a cycle if and only if `count_o` increases by one at the following clock edge.
- R9: A change of `src_sel_i` acts in the same cycle it is presented. The synchronizer and edge history run continuously, so switching to the pin source while the pin is held high does not produce a tick.
- R10: A level held high on `rtc_async_i` yields exactly one step, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable |
| src_sel_i | input | 1 | Tick source: 0 = divide-by-eight prescaler, 1 = real-time clock pin |
| rtc_async_i | input | 1 | Slow real-time clock, asynchronous to `clk` |
| load_i | input | 1 | Synchronous load strobe |
| load_val_i | input | 64 | Value written on load |
| count_o | output | 64 | Current time base value |
| tick_o | output | 1 | High in cycles where the count steps at the next edge |

## Verification
`tick_o` is combinational from the current state and the inputs. The bench therefore drives inputs just after a falling edge and samples `tick_o` one nanosecond later, in the same cycle. A step or a load appears on `count_o` one rising edge later, so the count is compared just after that edge. A rising edge on the pin reaches `count_o` at the third rising edge, and a fresh enable reaches it at the eighth. The directed cases count steps of exactly those lengths and check that the count is still unchanged one step early. The random phase compares every cycle against a bench model advanced by the same rules.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    typedef enum logic {
        SRC_DIV8 = 1'b0,
        SRC_RTC  = 1'b1
    } tb_src_e;

    typedef struct packed {
        logic    enable;
        tb_src_e source;
        logic    load;
    } tb_ctrl_t;

    typedef struct packed {
        logic div_tick;
        logic rtc_tick;
    } tb_ticks_t;

    function automatic logic pick_tick(input tb_ctrl_t c, input tb_ticks_t t);
        logic raw;
        raw = (c.source == SRC_RTC) ? t.rtc_tick : t.div_tick;
        return c.enable & raw & ~c.load;
    endfunction

endpackage

// File: rtl/tb_prescaler.sv
module tb_prescaler #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [DIV_LOG2-1:0] PHASE_LAST = {DIV_LOG2{1'b1}};

    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && (phase_q == PHASE_LAST);

    assert_phase_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (phase_q == '0));

    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        run_i |=> (phase_q == $past(phase_q) + 1'b1));

endmodule

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_DEPTH-1:0] stage_q;
    logic                  hist_q;

    for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= 1'b0;
                else     stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= 1'b0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= stage_q[SYNC_DEPTH-1];
    end

    assign rise_o = stage_q[SYNC_DEPTH-1] & ~hist_q;

    assert_single_rise_R10: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tb_count_reg.sv
module tb_count_reg #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_q == $past(load_val_i)));

endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
    import timebase_pkg::*;
#(
    parameter int CNT_W      = 64,
    parameter int DIV_LOG2   = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             src_sel_i,
    input  logic             rtc_async_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o
);
    tb_ctrl_t  ctrl;
    tb_ticks_t ticks;
    logic      step;

    assign ctrl.enable = en_i;
    assign ctrl.source = tb_src_e'(src_sel_i);
    assign ctrl.load   = load_i;

    tb_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (en_i),
        .tick_o (ticks.div_tick)
    );

    rtc_edge_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (rtc_async_i),
        .rise_o  (ticks.rtc_tick)
    );

    assign step = pick_tick(ctrl, ticks);

    tb_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .step_i     (step),
        .count_o    (count_o)
    );

    assign tick_o = step;

    assert_step_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (count_o == $past(count_o) + 1'b1));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_o && !load_i) |=> $stable(count_o));

    assert_off_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !tick_o);

    assert_load_masks_tick_R6: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !tick_o);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_o && (&count_o)) |=> (count_o == '0));

endmodule

// File: tb/test_timebase_counter.sv
module test_timebase_counter;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_i = 1'b0;
    logic         src_sel_i = 1'b0;
    logic         rtc_async_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] load_val_i = '0;
    logic [W-1:0] count_o;
    logic         tick_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_cnt;
    logic [2:0]   m_phase;
    logic         m_s1, m_s2, m_s3;

    always #2.5 clk = ~clk;

    timebase_counter i_timebase_counter (
        .clk(clk), .rst(rst), .en_i(en_i), .src_sel_i(src_sel_i),
        .rtc_async_i(rtc_async_i), .load_i(load_i), .load_val_i(load_val_i),
        .count_o(count_o), .tick_o(tick_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_advance(input logic en, input logic sel);
        if (!en) return 1'b0;
        if (sel) return m_s2 && !m_s3;
        return m_phase == 3'd7;
    endfunction

    task automatic step(input logic en, input logic sel, input logic rtc,
                        input logic ld, input logic [W-1:0] val, input string tag);
        logic adv;
        @(negedge clk);
        en_i = en; src_sel_i = sel; rtc_async_i = rtc; load_i = ld; load_val_i = val;
        #1;
        adv = exp_advance(en, sel);
        chk("R8 tick", {63'd0, tick_o}, {63'd0, adv && !ld});
        @(posedge clk);
        if (ld) m_cnt = val;
        else if (adv) m_cnt = m_cnt + 1'b1;
        m_phase = en ? m_phase + 3'd1 : 3'd0;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = rtc;
        #1;
        chk(tag, count_o, m_cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] c0;
        logic r;
        int hold;
        void'($urandom(32'd7321));
        m_cnt = '0; m_phase = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 count in reset", count_o, '0);
        chk("R1 tick in reset", {63'd0, tick_o}, '0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 count after reset", count_o, '0);

        // R2: disabled, pin toggling
        for (int i = 0; i < 24; i++) step(0, i[3], i[1], 0, '0, "R2");
        chk("R2 held", count_o, '0);

        // R3 / R5: first step on eighth enabled edge
        for (int i = 0; i < 7; i++) step(1, 0, i[0], 0, '0, "R3");
        chk("R5 not yet", count_o, 64'd0);
        step(1, 0, 0, 0, '0, "R3");
        chk("R5 first step", count_o, 64'd1);
        for (int i = 0; i < 72; i++) step(1, 0, i[1], 0, '0, "R3");
        chk("R3 rate", count_o, 64'd10);

        // R5: disable mid-phase restarts a full eight
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, '0, "R5");
        step(0, 0, 0, 0, '0, "R5");
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, '0, "R5");
        chk("R5 restart hold", count_o, 64'd10);
        step(1, 0, 0, 0, '0, "R5");
        chk("R5 restart step", count_o, 64'd11);

        // R4 / R10: pin source
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, '0, "R4");
        c0 = count_o;
        step(1, 1, 1, 0, '0, "R4");
        step(1, 1, 1, 0, '0, "R4");
        chk("R4 latency early", count_o, c0);
        step(1, 1, 1, 0, '0, "R4");
        chk("R4 latency third edge", count_o, c0 + 1);
        for (int i = 0; i < 6; i++) step(1, 1, 1, 0, '0, "R10");
        chk("R10 held level", count_o, c0 + 1);
        for (int i = 0; i < 16; i++) step(1, 1, i[1], 0, '0, "R4");
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, '0, "R4");
        chk("R4 four pulses", count_o, c0 + 5);

        // R9: switch to pin source while pin held high
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, '0, "R9");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, '0, "R9");
        c0 = count_o;
        for (int i = 0; i < 6; i++) step(1, 1, 1, 0, '0, "R9");
        chk("R9 no spurious tick", count_o, c0);

        // R6: load collides with a pin tick
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, '0, "R6");
        step(1, 1, 1, 0, '0, "R6");
        step(1, 1, 1, 0, '0, "R6");
        @(negedge clk);
        en_i = 1; src_sel_i = 1; rtc_async_i = 1; load_i = 1; load_val_i = 64'h1234;
        #1;
        chk("R6 tick masked", {63'd0, tick_o}, '0);
        @(posedge clk); #1;
        m_cnt = 64'h1234; m_phase = m_phase + 3'd1; m_s3 = m_s2; m_s2 = m_s1; m_s1 = 1;
        chk("R6 load wins", count_o, 64'h1234);

        // R7: wrap
        step(0, 0, 1, 1, '1, "R7");
        chk("R7 loaded ones", count_o, '1);
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0, '0, "R7");
        chk("R7 wrap", count_o, '0);

        // random phase
        r = 1; hold = 0;
        for (int i = 0; i < 3000; i++) begin
            logic e, s, l;
            hold++;
            if (hold >= 2 && ($urandom % 3) == 0) begin r = ~r; hold = 0; end
            e = ($urandom % 8) != 0;
            s = (i / 40) % 2 == 1;
            l = ($urandom % 40) == 0;
            step(e, s, r, l, {$urandom, $urandom}, s ? "R4" : "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule